// File: doc/BRIEF.md
# Banked Pin Function Controller

This block configures a set of I/O banks, each with 32 pins, for an external pad ring. A single 32-bit register bus gives access to the configuration. The bus carries a byte address, a write strobe, write data and combinational read data. Each bank owns a window of nine words. Four words hold the per-pin function codes, one word holds the pin data bits, two words hold the drive levels and two words hold the pull settings. The windows sit back to back at a stride of 36 bytes.

For every pin the block drives the following outputs continuously: the function code, the output value, the output enable, the drive level, the pull selection, and a flag that hands the pin to the interrupt logic. Pad input levels pass through a two-stage synchronizer. They are returned on data-register reads for pins that are not in output mode.

Top module: `pinmux_ctrl`

## Requirements
- R1: Synchronous reset (`rst` high at a rising edge) clears every register. After reset, all pad outputs are zero, and every defined register reads zero. Pins with data bit 0 also read zero from the data word, because their pad input is low.
- R2: Bank `b` occupies byte addresses `b*0x24` to `b*0x24+0x23`. Within each window the word offsets are laid out as follows: function words at 0x00, 0x04, 0x08 and 0x0C; the data word at 0x10; drive words at 0x14 and 0x18; pull words at 0x1C and 0x20.
- R3: Each function word holds eight 4-bit codes. Pin `8*w+k` of the bank uses bits `4k+3:4k` of function word `w`. The code appears on `pad_func` at bits `4p+3:4p`, where `p` is the global pin number `32*b + pin`.
- R4: A pin whose code is 1 has `pad_oe` set. Every other code clears `pad_oe`.
- R5: A pin whose code is 6 has `pad_irq_sel` set. Every other code clears it. `pad_oe` and `pad_irq_sel` are never both set for the same pin.
- R6: A write to the data word stores one bit per pin, with bit `k` belonging to pin `k`. `pad_out` shows the stored bit from the next clock edge on.
- R7: A read of the data word returns bit `k` as follows. If pin `k` has code 1, the bit is its stored data bit. Otherwise the bit is the pad input level. A change on `pad_in` becomes visible on this read after the second rising edge that follows it.
- R8: Each drive word holds sixteen 2-bit fields. Pin `16*w+k` uses bits `2k+1:2k` of drive word `w`, and the field appears on `pad_drive` at bits `2p+1:2p`.
- R9: Pull words follow the same packing as drive words, and their fields appear on `pad_pull` at bits `2p+1:2p`.
- R10: An access is undefined if the address is not word aligned or the bank index is not below `NUM_BANKS`. An undefined access reads zero, and a write to it changes no register and no pad output.
- R11: Function, drive and pull words read back the last value written to them. A write takes effect at the clock edge that samples it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | ADDR_W | Byte address |
| bus_we | input | 1 | Write strobe |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr` (combinational) |
| pad_in | input | NP | Pad input levels (NP = 32*NUM_BANKS) |
| pad_out | output | NP | Output value per pin |
| pad_oe | output | NP | Output enable per pin |
| pad_drive | output | 2*NP | Drive level per pin |
| pad_pull | output | 2*NP | Pull selection per pin |
| pad_func | output | 4*NP | Function code per pin |
| pad_irq_sel | output | NP | Pin routed to interrupt logic |

## Verification
Several properties are checked on every cycle:
- the cleared state after reset;
- a data-word write landing exactly in the data register;
- a function-word write landing in the addressed word;
- output enable and interrupt routing never being set together;
- zero read data on undefined addresses;
- unchanged pad outputs after an undefined write.

Other behaviours only the bench scenarios can show:
- the field packing across words and banks;
- the mixed read of the data word, where stored bits and pad levels are merged per pin;
- the exact two-edge synchronizer latency;
- the fact that an undefined write does not alias into a neighbouring bank.

// File: rtl/pinmux_pkg.sv
package pinmux_pkg;

    localparam int PINS_PER_BANK = 32;
    localparam int BANK_BYTES    = 36;
    localparam int FUNC_W        = 4;
    localparam int LVL_W         = 2;

    localparam logic [FUNC_W-1:0] CODE_INPUT  = 4'd0;
    localparam logic [FUNC_W-1:0] CODE_OUTPUT = 4'd1;
    localparam logic [FUNC_W-1:0] CODE_IRQ    = 4'd6;

    typedef enum logic [3:0] {
        W_FUNC0 = 4'd0,
        W_FUNC1 = 4'd1,
        W_FUNC2 = 4'd2,
        W_FUNC3 = 4'd3,
        W_DATA  = 4'd4,
        W_DRV0  = 4'd5,
        W_DRV1  = 4'd6,
        W_PULL0 = 4'd7,
        W_PULL1 = 4'd8
    } word_e;

    typedef struct packed {
        logic       hit;
        logic [7:0] bank;
        word_e      word;
    } dec_t;

    function automatic logic is_output(input logic [FUNC_W-1:0] code);
        return code == CODE_OUTPUT;
    endfunction

    function automatic logic is_irq(input logic [FUNC_W-1:0] code);
        return code == CODE_IRQ;
    endfunction

endpackage

// File: rtl/pinmux_addr_dec.sv
module pinmux_addr_dec
    import pinmux_pkg::*;
#(
    parameter int NUM_BANKS = 2,
    parameter int ADDR_W    = 8
) (
    input  logic [ADDR_W-1:0] addr,
    output dec_t              dec
);
    localparam logic [ADDR_W-1:0] STRIDE = ADDR_W'(BANK_BYTES);

    logic [ADDR_W-1:0] bank_idx;
    logic [ADDR_W-1:0] offset;

    always_comb begin
        bank_idx = addr / STRIDE;
        offset   = addr % STRIDE;
        dec.bank = 8'(bank_idx);
        dec.word = word_e'(offset[5:2]);
        dec.hit  = (addr[1:0] == 2'b00) && (bank_idx < ADDR_W'(NUM_BANKS));
    end
endmodule

// File: rtl/pinmux_sync.sv
module pinmux_sync #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] stage1;

    always_ff @(posedge clk) begin
        if (rst) begin
            stage1 <= '0;
            q      <= '0;
        end else begin
            stage1 <= d;
            q      <= stage1;
        end
    end
endmodule

// File: rtl/pinmux_bank.sv
module pinmux_bank
    import pinmux_pkg::*;
(
    input  logic                             clk,
    input  logic                             rst,
    input  logic                             we,
    input  word_e                            word,
    input  logic [31:0]                      wdata,
    input  logic [PINS_PER_BANK-1:0]         pad_sync,
    output logic [31:0]                      rdata,
    output logic [PINS_PER_BANK-1:0]         out_o,
    output logic [PINS_PER_BANK-1:0]         oe_o,
    output logic [PINS_PER_BANK-1:0]         irq_o,
    output logic [FUNC_W*PINS_PER_BANK-1:0]  func_o,
    output logic [LVL_W*PINS_PER_BANK-1:0]   drive_o,
    output logic [LVL_W*PINS_PER_BANK-1:0]   pull_o
);
    localparam int FUNC_PER_WORD = 32 / FUNC_W;
    localparam int LVL_PER_WORD  = 32 / LVL_W;
    localparam int FUNC_WORDS    = PINS_PER_BANK / FUNC_PER_WORD;
    localparam int LVL_WORDS     = PINS_PER_BANK / LVL_PER_WORD;

    logic [31:0] func_w [FUNC_WORDS];
    logic [31:0] drv_w  [LVL_WORDS];
    logic [31:0] pull_w [LVL_WORDS];
    logic [PINS_PER_BANK-1:0] data_w;
    logic [PINS_PER_BANK-1:0] data_rd;

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < FUNC_WORDS; i++) func_w[i] <= '0;
            for (int i = 0; i < LVL_WORDS; i++) begin
                drv_w[i]  <= '0;
                pull_w[i] <= '0;
            end
            data_w <= '0;
        end else if (we) begin
            case (word)
                W_FUNC0: func_w[0] <= wdata;
                W_FUNC1: func_w[1] <= wdata;
                W_FUNC2: func_w[2] <= wdata;
                W_FUNC3: func_w[3] <= wdata;
                W_DATA:  data_w    <= wdata;
                W_DRV0:  drv_w[0]  <= wdata;
                W_DRV1:  drv_w[1]  <= wdata;
                W_PULL0: pull_w[0] <= wdata;
                W_PULL1: pull_w[1] <= wdata;
                default: ;
            endcase
        end
    end

    for (genvar k = 0; k < PINS_PER_BANK; k++) begin : g_pin
        logic [FUNC_W-1:0] code;
        assign code = func_w[k / FUNC_PER_WORD][FUNC_W*(k % FUNC_PER_WORD) +: FUNC_W];
        assign func_o[FUNC_W*k +: FUNC_W] = code;
        assign drive_o[LVL_W*k +: LVL_W] = drv_w[k / LVL_PER_WORD][LVL_W*(k % LVL_PER_WORD) +: LVL_W];
        assign pull_o[LVL_W*k +: LVL_W]  = pull_w[k / LVL_PER_WORD][LVL_W*(k % LVL_PER_WORD) +: LVL_W];
        assign oe_o[k]    = is_output(code);
        assign irq_o[k]   = is_irq(code);
        assign data_rd[k] = is_output(code) ? data_w[k] : pad_sync[k];
    end

    assign out_o = data_w;

    always_comb begin
        case (word)
            W_FUNC0: rdata = func_w[0];
            W_FUNC1: rdata = func_w[1];
            W_FUNC2: rdata = func_w[2];
            W_FUNC3: rdata = func_w[3];
            W_DATA:  rdata = data_rd;
            W_DRV0:  rdata = drv_w[0];
            W_DRV1:  rdata = drv_w[1];
            W_PULL0: rdata = pull_w[0];
            W_PULL1: rdata = pull_w[1];
            default: rdata = '0;
        endcase
    end

    // R1: reset leaves every stored field cleared
    assert_reset_clear_R1: assert property (@(posedge clk)
        rst |=> (out_o == '0 && func_o == '0 && drive_o == '0 && pull_o == '0));

    // R6: a data-word write shows up on pad_out one edge later
    assert_data_write_R6: assert property (@(posedge clk) disable iff (rst)
        (we && word == W_DATA) |=> (out_o == $past(wdata)));

    // R3: a write to function word 0 lands in pins 0..7
    assert_func_write_R3: assert property (@(posedge clk) disable iff (rst)
        (we && word == W_FUNC0) |=> (func_o[31:0] == $past(wdata)));

    // R5: output enable and interrupt routing exclude each other
    assert_oe_irq_excl_R5: assert property (@(posedge clk) disable iff (rst)
        (oe_o & irq_o) == '0);
endmodule

// File: rtl/pinmux_ctrl.sv
module pinmux_ctrl
    import pinmux_pkg::*;
#(
    parameter int NUM_BANKS = 2,
    parameter int ADDR_W    = 8,
    localparam int NP       = NUM_BANKS * PINS_PER_BANK
) (
    input  logic                clk,
    input  logic                rst,
    input  logic [ADDR_W-1:0]   bus_addr,
    input  logic                bus_we,
    input  logic [31:0]         bus_wdata,
    output logic [31:0]         bus_rdata,
    input  logic [NP-1:0]       pad_in,
    output logic [NP-1:0]       pad_out,
    output logic [NP-1:0]       pad_oe,
    output logic [LVL_W*NP-1:0] pad_drive,
    output logic [LVL_W*NP-1:0] pad_pull,
    output logic [FUNC_W*NP-1:0] pad_func,
    output logic [NP-1:0]       pad_irq_sel
);
    localparam int PB = PINS_PER_BANK;

    dec_t        dec;
    logic [NP-1:0] pad_sync;
    logic [31:0] bank_rd [NUM_BANKS];

    pinmux_addr_dec #(.NUM_BANKS(NUM_BANKS), .ADDR_W(ADDR_W)) u_dec (
        .addr (bus_addr),
        .dec  (dec)
    );

    pinmux_sync #(.W(NP)) u_sync (
        .clk (clk),
        .rst (rst),
        .d   (pad_in),
        .q   (pad_sync)
    );

    for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
        logic sel;
        assign sel = dec.hit && (dec.bank == 8'(b));

        pinmux_bank u_bank (
            .clk      (clk),
            .rst      (rst),
            .we       (bus_we && sel),
            .word     (dec.word),
            .wdata    (bus_wdata),
            .pad_sync (pad_sync[PB*b +: PB]),
            .rdata    (bank_rd[b]),
            .out_o    (pad_out[PB*b +: PB]),
            .oe_o     (pad_oe[PB*b +: PB]),
            .irq_o    (pad_irq_sel[PB*b +: PB]),
            .func_o   (pad_func[FUNC_W*PB*b +: FUNC_W*PB]),
            .drive_o  (pad_drive[LVL_W*PB*b +: LVL_W*PB]),
            .pull_o   (pad_pull[LVL_W*PB*b +: LVL_W*PB])
        );
    end

    always_comb begin
        bus_rdata = '0;
        for (int b = 0; b < NUM_BANKS; b++) begin
            if (dec.hit && dec.bank == 8'(b)) bus_rdata = bank_rd[b];
        end
    end

    // R10: undefined addresses read as zero
    assert_undef_read_R10: assert property (@(posedge clk) disable iff (rst)
        !dec.hit |-> bus_rdata == '0);

    // R10: an undefined write leaves every pad output unchanged
    assert_undef_write_R10: assert property (@(posedge clk) disable iff (rst)
        (bus_we && !dec.hit) |=> ($stable(pad_out) && $stable(pad_func) &&
                                  $stable(pad_drive) && $stable(pad_pull)));
endmodule

// File: tb/test_pinmux_ctrl.sv
module test_pinmux_ctrl;
    localparam int NB = 2;
    localparam int AW = 8;
    localparam int NP = NB * 32;

    logic            clk = 1'b0;
    logic            rst;
    logic [AW-1:0]   bus_addr;
    logic            bus_we;
    logic [31:0]     bus_wdata;
    logic [31:0]     bus_rdata;
    logic [NP-1:0]   pad_in;
    logic [NP-1:0]   pad_out;
    logic [NP-1:0]   pad_oe;
    logic [2*NP-1:0] pad_drive;
    logic [2*NP-1:0] pad_pull;
    logic [4*NP-1:0] pad_func;
    logic [NP-1:0]   pad_irq_sel;

    int tests = 0;
    int fails = 0;
    bit done  = 1'b0;

    always #10 clk = ~clk;

    pinmux_ctrl #(.NUM_BANKS(NB), .ADDR_W(AW)) i_pinmux_ctrl (
        .clk, .rst, .bus_addr, .bus_we, .bus_wdata, .bus_rdata,
        .pad_in, .pad_out, .pad_oe, .pad_drive, .pad_pull, .pad_func, .pad_irq_sel
    );

    // {address, write data, expected read-back}
    localparam logic [71:0] VEC [11] = '{
        {8'h00, 32'h76543210, 32'h76543210},  // R3 R11
        {8'h0C, 32'hFFFFFFFF, 32'hFFFFFFFF},  // R3
        {8'h14, 32'hA5A5A5A5, 32'hA5A5A5A5},  // R8
        {8'h18, 32'h5A5A5A5A, 32'h5A5A5A5A},  // R8
        {8'h1C, 32'h12345678, 32'h12345678},  // R9
        {8'h20, 32'h0F0F0F0F, 32'h0F0F0F0F},  // R9
        {8'h24, 32'h11111111, 32'h11111111},  // R2 bank 1 function word 0
        {8'h44, 32'hCAFEF00D, 32'hCAFEF00D},  // R2 bank 1 pull word 1
        {8'h48, 32'hDEADBEEF, 32'h00000000},  // R10 bank 2 absent
        {8'h26, 32'hFFFFFFFF, 32'h00000000},  // R10 unaligned
        {8'hFC, 32'h13579BDF, 32'h00000000}   // R10 beyond windows
    };

    task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic bus_write(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_addr  = a;
        bus_wdata = d;
        bus_we    = 1'b1;
        @(negedge clk);
        bus_we    = 1'b0;
    endtask

    task automatic bus_read(input logic [7:0] a, output logic [31:0] d);
        @(negedge clk);
        bus_addr = a;
        #1 d = bus_rdata;
    endtask

    initial begin
        #(20 * 100000);
        if (!done) begin
            tests++;
            fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    initial begin
        logic [31:0] r;
        logic [NP-1:0]   s_out;
        logic [4*NP-1:0] s_func;
        rst = 1'b1; bus_we = 1'b0; bus_addr = '0; bus_wdata = '0; pad_in = '0;
        repeat (3) @(negedge clk);
        rst = 1'b0;

        // R1 reset state
        check("R1 pad_oe", 64'(pad_oe), 64'h0);
        check("R1 pad_func", 64'(pad_func[63:0]), 64'h0);
        bus_read(8'h00, r); check("R1 func read", 64'(r), 64'h0);
        bus_read(8'h10, r); check("R1 data read", 64'(r), 64'h0);

        for (int i = 0; i < 11; i++) begin
            bus_write(VEC[i][71:64], VEC[i][63:32]);
            bus_read(VEC[i][71:64], r);
            check("R2/R3/R8/R9/R10/R11 vector", 64'(r), 64'(VEC[i][31:0]));
        end

        // R3 function codes on the pad side
        check("R3 pad_func bank0", 64'(pad_func[31:0]), 64'h76543210);
        check("R2 pad_func bank1", 64'(pad_func[159:128]), 64'h11111111);
        // R4 only code 1 enables the output
        check("R4 pad_oe bank0", 64'(pad_oe[31:0]), 64'h00000002);
        check("R4 pad_oe bank1", 64'(pad_oe[39:32]), 64'hFF);
        // R5 only code 6 routes to interrupts
        check("R5 irq bank0", 64'(pad_irq_sel[31:0]), 64'h00000040);
        check("R5 irq bank1", 64'(pad_irq_sel[63:32]), 64'h0);
        // R8 R9 field placement
        check("R8 pad_drive", 64'(pad_drive[63:0]), 64'h5A5A5A5AA5A5A5A5);
        check("R9 pad_pull", 64'(pad_pull[63:0]), 64'h0F0F0F0F12345678);
        check("R9 pad_pull bank1 word1", 64'(pad_pull[127:96]), 64'hCAFEF00D);

        // R6 data word drives pad_out
        bus_write(8'h10, 32'h00000003);
        check("R6 pad_out", 64'(pad_out[31:0]), 64'h3);

        // R7 mixed read and synchronizer latency
        bus_read(8'h10, r); check("R7 before pad change", 64'(r), 64'h2);
        pad_in[31:0] = 32'h000000F0;
        @(negedge clk); #1 check("R7 one edge later", 64'(bus_rdata), 64'h2);
        @(negedge clk); #1 check("R7 two edges later", 64'(bus_rdata), 64'hF2);

        // R10 undefined writes alter nothing
        s_out = pad_out; s_func = pad_func;
        bus_write(8'h48, 32'hFFFFFFFF);
        bus_write(8'h27, 32'h00000000);
        check("R10 pad_out stable", 64'(pad_out), 64'(s_out));
        check("R10 pad_func stable", 64'(pad_func[63:0]), 64'(s_func[63:0]));
        bus_read(8'h24, r); check("R10 bank1 untouched", 64'(r), 64'h11111111);

        // R1 reset mid-run
        @(negedge clk); rst = 1'b1;
        @(negedge clk); rst = 1'b0;
        bus_read(8'h24, r); check("R1 reset clears bank1", 64'(r), 64'h0);
        check("R1 reset clears pad_out", 64'(pad_out), 64'h0);

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule